// File: doc/BRIEF.md
# TFT Panel Scan Timing Controller

The block produces all timing for a 320x240 TFT panel that takes 18 bits per pixel. The panel's image sits in a frame buffer made of byte-wide memory. The block runs on a master clock at three times the pixel rate, so each pixel has a slot of three master cycles. Inside each slot the block fetches, in order, the three bytes of the *next* pixel through a valid/ready request port. It packs those bytes into one pixel word. The word is shown during the following slot.

When a pixel's three bytes have arrived, the request drops and the fetch address holds until the slot ends. At the start of each frame the address goes back to a fixed base.

A single free-running position counter sets every panel strobe. The counter has three fields: phase within the pixel, column and row, with blanking columns and rows added after the visible area. The strobes are decoded from this counter and are registered on the falling clock edge. The counter itself advances on the rising edge. Outputs therefore move half a cycle away from counter transitions.

If a byte has not arrived when its slot ends, the block raises an underrun pulse. The missing byte is shown as zero.

Top module: `tft_scan_ctrl`

## Requirements
- R1: While rst_ni is low, every panel strobe, pix_data_o and underrun_o are 0. After release, the counter starts in the last slot of the frame, which is the fetch slot for pixel 0.
- R2: The fetch slot of visible pixel n (n = row*H_ACTIVE + col) is the slot just before that pixel's display slot. In its fetch slot the block requests bytes at FRAME_BASE + 3n, +1, +2, one per accepted handshake, where a handshake is fetch_valid_o and fetch_ready_i high at a rising edge.
- R3: The pixel word is the low 18 bits of {byte0, byte1, byte2}. Byte 0 is the first fetched and is most significant, so bits 17:16 are byte0[1:0] and byte0[7:2] are dropped. pix_data_o carries this word during the pixel's display slot.
- R4: After three handshakes in a slot, fetch_valid_o stays low until the slot ends, and fetch_addr_o holds at FRAME_BASE + 3n + 3.
- R5: If fewer than three bytes are accepted in a fetch slot, underrun_o is high for exactly the first cycle of the display slot, and the missing bytes read as zero.
- R6: pix_clk_o is high during phase 1 of every slot and low in phases 0 and 2, so its period is three master cycles.
- R7: data_en_o is high exactly in slots with column < H_ACTIVE and row < V_ACTIVE. pix_data_o is zero whenever data_en_o is low.
- R8: line_pulse_o is high for the whole slot at column H_ACTIVE (the first blanking column) of each visible row, and never while data_en_o is high.
- R9: line_start_o is high for the slot at column 0 of each visible row. frame_start_o is high only for column 0 of row 0, and so coincides with the first visible pixel.
- R10: All panel strobes change only on the falling clock edge. They keep their value across the rising edge.
- R11: After the last visible pixel of a frame is fetched, the fetch address returns to FRAME_BASE for the next frame. This also holds after a reset applied in mid-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, three times the pixel rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fetch_valid_o | output | 1 | Byte request pending |
| fetch_addr_o | output | ADDR_W | Byte address of the request |
| fetch_ready_i | input | 1 | Memory accepts the request; fetch_data_i is valid in the same cycle |
| fetch_data_i | input | MEM_W | Byte returned for the accepted request |
| pix_clk_o | output | 1 | Panel pixel clock |
| data_en_o | output | 1 | High in visible pixel slots |
| pix_data_o | output | PIX_W | Pixel word for the panel |
| line_pulse_o | output | 1 | Line latch pulse after each visible line |
| line_start_o | output | 1 | Horizontal start at the first pixel of a visible line |
| frame_start_o | output | 1 | Vertical start at the first pixel of the frame |
| underrun_o | output | 1 | One-cycle pulse when a pixel's bytes arrived late |

## Verification
The assertions rely on the memory side presenting fetch_data_i in the same cycle as fetch_ready_i. They also rely on fetch_ready_i changing only between clock edges. Both are how the bench's memory model behaves: it looks up the byte combinationally from fetch_addr_o, and sets ready at mid-cycle from its own model of the slot position.

Starved slots are produced by masking ready in chosen phases of chosen pixels. These are the only departures from a prompt memory. The checks on the underrun pulse and on zero-filled bytes cover exactly these cases.

Reset is applied and released at mid-cycle, including once in the middle of a frame.

// File: rtl/tft_scan_pkg.sv
package tft_scan_pkg;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  typedef struct packed {
    logic pclk;
    logic den;
    logic lpulse;
    logic lstart;
    logic fstart;
  } strobe_t;

endpackage

// File: rtl/tft_scan_pos.sv
module tft_scan_pos #(
  parameter int unsigned WORDS   = 3,
  parameter int unsigned H_TOTAL = 336,
  parameter int unsigned V_TOTAL = 244,
  parameter int unsigned PH_W    = $clog2(WORDS),
  parameter int unsigned COL_W   = $clog2(H_TOTAL),
  parameter int unsigned ROW_W   = $clog2(V_TOTAL)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [PH_W-1:0]  phase_o,
  output logic [COL_W-1:0] col_o,
  output logic [ROW_W-1:0] row_o,
  output logic             slot_end_o
);

  logic [PH_W-1:0]  phase_q;
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;

  assign slot_end_o = (phase_q == PH_W'(WORDS - 1));

  // reset parks the counter in the final slot, which prefetches pixel 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      col_q   <= COL_W'(H_TOTAL - 1);
      row_q   <= ROW_W'(V_TOTAL - 1);
    end else if (slot_end_o) begin
      phase_q <= '0;
      if (col_q == COL_W'(H_TOTAL - 1)) begin
        col_q <= '0;
        row_q <= (row_q == ROW_W'(V_TOTAL - 1)) ? '0 : row_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign phase_o = phase_q;
  assign col_o   = col_q;
  assign row_o   = row_q;

endmodule

// File: rtl/tft_fetch_gather.sv
module tft_fetch_gather #(
  parameter int unsigned WORDS      = 3,
  parameter int unsigned MEM_W      = 8,
  parameter int unsigned PIX_W      = 18,
  parameter int unsigned ADDR_W     = 18,
  parameter int unsigned FRAME_BASE = 0,
  parameter int unsigned H_ACTIVE   = 320,
  parameter int unsigned V_ACTIVE   = 240,
  parameter int unsigned H_TOTAL    = 336,
  parameter int unsigned V_TOTAL    = 244,
  parameter int unsigned COL_W      = $clog2(H_TOTAL),
  parameter int unsigned ROW_W      = $clog2(V_TOTAL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slot_end_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [ROW_W-1:0]  row_i,
  output logic              fetch_valid_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  input  logic              fetch_ready_i,
  input  logic [MEM_W-1:0]  fetch_data_i,
  output logic [PIX_W-1:0]  pix_o,
  output logic              underrun_o
);

  localparam int unsigned K_W    = $clog2(WORDS + 1);
  localparam int unsigned GATH_W = WORDS * MEM_W;

  logic             last_col, f_act, frame_last, take;
  logic [COL_W-1:0] tgt_col;
  logic [ROW_W-1:0] tgt_row, nxt_row;
  logic [K_W-1:0]   k_q, k_n;
  logic [ADDR_W-1:0] base_q;
  logic [MEM_W-1:0] buf_q [WORDS];
  logic [MEM_W-1:0] buf_n [WORDS];
  logic [GATH_W-1:0] gather_n;
  logic [PIX_W-1:0] pix_q;
  logic             underrun_q;

  // the slot being scanned fetches the pixel of the following slot
  assign last_col   = (col_i == COL_W'(H_TOTAL - 1));
  assign nxt_row    = (row_i == ROW_W'(V_TOTAL - 1)) ? '0 : row_i + 1'b1;
  assign tgt_col    = last_col ? '0 : col_i + 1'b1;
  assign tgt_row    = last_col ? nxt_row : row_i;
  assign f_act      = (tgt_col < COL_W'(H_ACTIVE)) && (tgt_row < ROW_W'(V_ACTIVE));
  assign frame_last = f_act && (tgt_col == COL_W'(H_ACTIVE - 1)) &&
                      (tgt_row == ROW_W'(V_ACTIVE - 1));

  assign fetch_valid_o = f_act && (k_q < K_W'(WORDS));
  assign take          = fetch_valid_o && fetch_ready_i;
  assign k_n           = k_q + K_W'(take);
  assign fetch_addr_o  = base_q + ADDR_W'(k_q);

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    assign buf_n[g] = (take && (k_q == K_W'(g))) ? fetch_data_i : buf_q[g];
    // first fetched byte lands most significant
    assign gather_n[(WORDS-1-g)*MEM_W +: MEM_W] = buf_n[g];
  end

  if (GATH_W > PIX_W) begin : g_drop
    logic unused_hi;
    assign unused_hi = ^gather_n[GATH_W-1:PIX_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      k_q        <= '0;
      base_q     <= ADDR_W'(FRAME_BASE);
      pix_q      <= '0;
      underrun_q <= 1'b0;
      for (int i = 0; i < WORDS; i++) buf_q[i] <= '0;
    end else begin
      underrun_q <= slot_end_i && f_act && (k_n < K_W'(WORDS));
      if (slot_end_i) begin
        k_q   <= '0;
        pix_q <= f_act ? gather_n[PIX_W-1:0] : '0;
        for (int i = 0; i < WORDS; i++) buf_q[i] <= '0;
        if (frame_last)  base_q <= ADDR_W'(FRAME_BASE);
        else if (f_act)  base_q <= base_q + ADDR_W'(WORDS);
      end else begin
        k_q <= k_n;
        for (int i = 0; i < WORDS; i++) buf_q[i] <= buf_n[i];
      end
    end
  end

  assign pix_o      = pix_q;
  assign underrun_o = underrun_q;

endmodule

// File: rtl/tft_strobe_gen.sv
module tft_strobe_gen
  import tft_scan_pkg::*;
#(
  parameter int unsigned WORDS    = 3,
  parameter int unsigned PIX_W    = 18,
  parameter int unsigned H_ACTIVE = 320,
  parameter int unsigned V_ACTIVE = 240,
  parameter int unsigned PH_W     = 2,
  parameter int unsigned COL_W    = 9,
  parameter int unsigned ROW_W    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PH_W-1:0]  phase_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [PIX_W-1:0] pix_i,
  output logic             pix_clk_o,
  output logic             data_en_o,
  output logic [PIX_W-1:0] pix_data_o,
  output logic             line_pulse_o,
  output logic             line_start_o,
  output logic             frame_start_o
);

  localparam int unsigned CLK_PH = WORDS / 2;

  strobe_t          dec, str_q;
  logic             row_ok, active;
  logic [PIX_W-1:0] data_q;

  always_comb begin
    row_ok     = (row_i < ROW_W'(V_ACTIVE));
    active     = row_ok && (col_i < COL_W'(H_ACTIVE));
    dec.pclk   = (phase_i == PH_W'(CLK_PH));
    dec.den    = active;
    dec.lpulse = row_ok && (col_i == COL_W'(H_ACTIVE));
    dec.lstart = row_ok && (col_i == '0);
    dec.fstart = (row_i == '0) && (col_i == '0);
  end

  // opposite edge: outputs settle half a cycle after the counter moves
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      str_q  <= '0;
      data_q <= '0;
    end else begin
      str_q  <= dec;
      data_q <= active ? pix_i : '0;
    end
  end

  assign pix_clk_o     = str_q.pclk;
  assign data_en_o     = str_q.den;
  assign line_pulse_o  = str_q.lpulse;
  assign line_start_o  = str_q.lstart;
  assign frame_start_o = str_q.fstart;
  assign pix_data_o    = data_q;

endmodule

// File: rtl/tft_scan_ctrl.sv
module tft_scan_ctrl
  import tft_scan_pkg::*;
#(
  parameter int unsigned PIX_W      = 18,
  parameter int unsigned MEM_W      = 8,
  parameter int unsigned H_ACTIVE   = 320,
  parameter int unsigned H_BLANK    = 16,
  parameter int unsigned V_ACTIVE   = 240,
  parameter int unsigned V_BLANK    = 4,
  parameter int unsigned ADDR_W     = 18,
  parameter int unsigned FRAME_BASE = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              fetch_valid_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  input  logic              fetch_ready_i,
  input  logic [MEM_W-1:0]  fetch_data_i,
  output logic              pix_clk_o,
  output logic              data_en_o,
  output logic [PIX_W-1:0]  pix_data_o,
  output logic              line_pulse_o,
  output logic              line_start_o,
  output logic              frame_start_o,
  output logic              underrun_o
);

  localparam int unsigned WORDS   = ceil_div(PIX_W, MEM_W);
  localparam int unsigned H_TOTAL = H_ACTIVE + H_BLANK;
  localparam int unsigned V_TOTAL = V_ACTIVE + V_BLANK;
  localparam int unsigned PH_W    = $clog2(WORDS);
  localparam int unsigned COL_W   = $clog2(H_TOTAL);
  localparam int unsigned ROW_W   = $clog2(V_TOTAL);

  logic [PH_W-1:0]  phase;
  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;
  logic             slot_end;
  logic [PIX_W-1:0] pix;

  tft_scan_pos #(
    .WORDS(WORDS), .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL),
    .PH_W(PH_W), .COL_W(COL_W), .ROW_W(ROW_W)
  ) u_pos (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .phase_o(phase), .col_o(col), .row_o(row), .slot_end_o(slot_end)
  );

  tft_fetch_gather #(
    .WORDS(WORDS), .MEM_W(MEM_W), .PIX_W(PIX_W), .ADDR_W(ADDR_W),
    .FRAME_BASE(FRAME_BASE), .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE),
    .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .COL_W(COL_W), .ROW_W(ROW_W)
  ) u_fetch (
    .clk_i(clk_i), .rst_ni(rst_ni), .slot_end_i(slot_end),
    .col_i(col), .row_i(row),
    .fetch_valid_o(fetch_valid_o), .fetch_addr_o(fetch_addr_o),
    .fetch_ready_i(fetch_ready_i), .fetch_data_i(fetch_data_i),
    .pix_o(pix), .underrun_o(underrun_o)
  );

  tft_strobe_gen #(
    .WORDS(WORDS), .PIX_W(PIX_W), .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE),
    .PH_W(PH_W), .COL_W(COL_W), .ROW_W(ROW_W)
  ) u_strobe (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .phase_i(phase), .col_i(col), .row_i(row), .pix_i(pix),
    .pix_clk_o(pix_clk_o), .data_en_o(data_en_o), .pix_data_o(pix_data_o),
    .line_pulse_o(line_pulse_o), .line_start_o(line_start_o),
    .frame_start_o(frame_start_o)
  );

endmodule

// File: rtl/tft_scan_chk.sv
module tft_scan_chk #(
  parameter int unsigned PIX_W = 18
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pix_clk_o,
  input logic             data_en_o,
  input logic [PIX_W-1:0] pix_data_o,
  input logic             line_pulse_o,
  input logic             line_start_o,
  input logic             frame_start_o,
  input logic             underrun_o
);

  assert_blank_data_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_en_o |-> (pix_data_o == '0));

  assert_pix_clk_one_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_clk_o |=> !pix_clk_o);

  assert_underrun_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> !underrun_o);

  assert_line_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_o |-> data_en_o);

  assert_frame_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> line_start_o);

  assert_lp_blank_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_pulse_o |-> !data_en_o);

  assert_lp_width_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(line_pulse_o) |=> line_pulse_o);

endmodule

bind tft_scan_ctrl tft_scan_chk #(.PIX_W(PIX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pix_clk_o(pix_clk_o),
  .data_en_o(data_en_o), .pix_data_o(pix_data_o),
  .line_pulse_o(line_pulse_o), .line_start_o(line_start_o),
  .frame_start_o(frame_start_o), .underrun_o(underrun_o)
);

// File: tb/tb_tft_scan_ctrl.sv
module tb_tft_scan_ctrl;

  localparam int HA = 4, HB = 2, VA = 3, VB = 1;
  localparam int HT = HA + HB, VT = VA + VB, W = 3;
  localparam int AW = 12, BASE = 64;
  localparam int FRAME = HT * VT * W;

  typedef struct packed {
    logic [7:0] pix;   // pixel whose fetch slot is starved
    logic [2:0] mask;  // bit p: ready in phase p
  } starve_t;

  localparam starve_t VEC [6] = '{
    '{8'd0,  3'b111}, '{8'd0,  3'b000}, '{8'd1, 3'b110},
    '{8'd5,  3'b011}, '{8'd11, 3'b101}, '{8'd6, 3'b100}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_ni;
  logic          fetch_valid, fetch_ready;
  logic [AW-1:0] fetch_addr;
  logic [7:0]    fetch_data;
  logic          pix_clk, data_en, line_pulse, line_start, frame_start, underrun;
  logic [17:0]   pix_data;

  tft_scan_ctrl #(
    .PIX_W(18), .MEM_W(8), .H_ACTIVE(HA), .H_BLANK(HB), .V_ACTIVE(VA),
    .V_BLANK(VB), .ADDR_W(AW), .FRAME_BASE(BASE)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .fetch_valid_o(fetch_valid), .fetch_addr_o(fetch_addr),
    .fetch_ready_i(fetch_ready), .fetch_data_i(fetch_data),
    .pix_clk_o(pix_clk), .data_en_o(data_en), .pix_data_o(pix_data),
    .line_pulse_o(line_pulse), .line_start_o(line_start),
    .frame_start_o(frame_start), .underrun_o(underrun)
  );

  function automatic logic [7:0] mem_byte(input int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  assign fetch_data = mem_byte(int'(fetch_addr));

  int checks = 0, errors = 0;
  bit done = 1'b0;

  int m_ph, m_col, m_row, mk, exp_pix, starve_pix;
  logic [2:0] starve_mask;
  logic [7:0] mb [3];
  bit exp_ur, prev_pclk, prev_de, prev_lp;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int tgt_index();
    int tc, tr;
    if (m_col == HT - 1) begin
      tc = 0;
      tr = (m_row == VT - 1) ? 0 : m_row + 1;
    end else begin
      tc = m_col + 1;
      tr = m_row;
    end
    if (tc < HA && tr < VA) return tr * HA + tc;
    return -1;
  endfunction

  task automatic set_ready();
    int t;
    t = tgt_index();
    fetch_ready = !(t >= 0 && t == starve_pix && !starve_mask[m_ph]);
  endtask

  task automatic init_model();
    m_ph = 0; m_col = HT - 1; m_row = VT - 1; mk = 0;
    exp_pix = 0; exp_ur = 1'b0;
    for (int i = 0; i < 3; i++) mb[i] = 8'h00;
    prev_pclk = pix_clk; prev_de = data_en; prev_lp = line_pulse;
  endtask

  task automatic step();
    int t;
    bit hs, act;
    t = tgt_index();
    chk(fetch_valid == (t >= 0 && mk < 3), "R2/R4 fetch_valid", fetch_valid, (t >= 0 && mk < 3));
    if (t >= 0)
      chk(int'(fetch_addr) == BASE + 3 * t + mk, "R2/R4/R11 fetch_addr",
          int'(fetch_addr), BASE + 3 * t + mk);
    hs = fetch_valid && fetch_ready;
    @(posedge clk);
    if (hs && mk < 3) begin
      mb[mk] = mem_byte(BASE + 3 * t + mk);
      mk++;
    end
    if (m_ph == W - 1) begin
      exp_ur = (t >= 0) && (mk < 3);
      if (t >= 0) exp_pix = int'({mb[0][1:0], mb[1], mb[2]});
      mk = 0;
      for (int i = 0; i < 3; i++) mb[i] = 8'h00;
      m_ph = 0;
      if (m_col == HT - 1) begin
        m_col = 0;
        m_row = (m_row == VT - 1) ? 0 : m_row + 1;
      end else m_col++;
    end else begin
      m_ph++;
      exp_ur = 1'b0;
    end
    #2;
    chk(pix_clk == prev_pclk && data_en == prev_de && line_pulse == prev_lp,
        "R10 strobe held over rising edge", {pix_clk, data_en, line_pulse},
        {prev_pclk, prev_de, prev_lp});
    #5;
    act = (m_col < HA) && (m_row < VA);
    chk(underrun == exp_ur, "R5 underrun", underrun, exp_ur);
    chk(pix_clk == (m_ph == 1), "R6 pix_clk", pix_clk, (m_ph == 1));
    chk(data_en == act, "R7 data_en", data_en, act);
    chk(int'(pix_data) == (act ? exp_pix : 0), "R3/R5/R7 pix_data", int'(pix_data),
        act ? exp_pix : 0);
    chk(line_pulse == (m_col == HA && m_row < VA), "R8 line_pulse", line_pulse,
        (m_col == HA && m_row < VA));
    chk(line_start == (m_col == 0 && m_row < VA), "R9 line_start", line_start,
        (m_col == 0 && m_row < VA));
    chk(frame_start == (m_col == 0 && m_row == 0), "R9 frame_start", frame_start,
        (m_col == 0 && m_row == 0));
    prev_pclk = pix_clk; prev_de = data_en; prev_lp = line_pulse;
    set_ready();
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    #1;
    chk({pix_clk, data_en, line_pulse, line_start, frame_start, underrun} == 6'b0,
        "R1 strobes in reset", {pix_clk, data_en, line_pulse, line_start, frame_start, underrun}, 0);
    repeat (3) @(posedge clk);
    #7;
    chk(pix_data == '0, "R1 data in reset", int'(pix_data), 0);
    chk(underrun == 1'b0, "R1 underrun in reset", underrun, 0);
    @(posedge clk);
    #2 rst_ni = 1'b1;
    #5;
    init_model();
    set_ready();
    chk(fetch_valid && int'(fetch_addr) == BASE, "R1/R11 first fetch after reset",
        int'(fetch_addr), BASE);
  endtask

  initial begin
    rst_ni = 1'b0;
    fetch_ready = 1'b1;
    starve_pix = -1;
    starve_mask = 3'b111;
    #2;
    do_reset();
    foreach (VEC[v]) begin
      starve_pix  = int'(VEC[v].pix);
      starve_mask = VEC[v].mask;
      set_ready();
      repeat (2 * FRAME) step();
    end
    // mid-frame reset, fetch restarts at base (R11)
    starve_pix = -1;
    set_ready();
    repeat (FRAME / 2 + 1) step();
    do_reset();
    repeat (FRAME + 10) step();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule